// File: doc/BRIEF.md
# Packetized Data Port with Interrupt Status

This block is the data-phase front end that sits between a 32-bit register bus and the byte stream of a flash data path. Software programs a packet register with a packet size in bytes and a packet count, then a command sequencer pulses a start input with the transfer direction. The transfer then moves through a single internal packet buffer one packet at a time, with a ready handshake toward software for every packet.

For a read, bytes arrive on an inbound valid/ready stream until one whole packet sits in the buffer; the block then flags buffer-read-ready and software drains the packet through one data-port register, four bytes per access. For a write, the block flags buffer-write-ready, software fills the packet through the same data-port register with byte, halfword or word strobes, and the block streams the packet out on an outbound valid/ready stream. Transfer-complete is flagged only after the final packet. All flags live in a write-one-to-clear status register whose bits are set only while the matching bit of a status-enable register is 1.

Stream rules: on both streams a byte moves on a clock edge where valid and ready are both high. `in_ready` never depends on `in_valid`, so the upstream source may stall freely. `out_valid` never depends on `out_ready`; once raised it stays high with `out_data` unchanged until the byte is taken, so the downstream sink may apply back-pressure for any number of cycles.

Top module: `pkt_dataport`

## Requirements
- R1: The packet register (bus offset 0) keeps the packet size in bits [10:0] and the packet count in bits [23:12]; it resets to 0 and reads back with every other bit 0.
- R2: The status register (bus offset 2) holds bit 0 buffer-write-ready, bit 1 buffer-read-ready, bit 2 transfer-complete, bit 3 multi-bit ECC error and bit 4 ECC error; it resets to 0, writing 1 to a bit clears it, and a set event in the same cycle as its clear leaves the bit set.
- R3: A status bit is set by an event only if bit of the same position in the status-enable register (bus offset 1, bits [4:0]) was 1 in that cycle; an event while it is 0 is lost.
- R4: A start pulse is taken only while idle and only if both packet size and packet count are nonzero; otherwise it has no effect (no stream activity, no status bit).
- R5: During a read packet `in_ready` is high exactly while fewer than packet-size bytes are buffered; buffer-read-ready is set one cycle after the edge that takes the packet's last byte.
- R6: A data-port read (bus offset 3) while a read packet is being drained returns the next four buffered bytes little-endian (earliest byte in bits [7:0]), with lanes past the packet end 0, and advances by the smaller of 4 and the bytes left; at any other time it returns 0 and changes nothing.
- R7: Buffer-write-ready is set on the edge that takes a write start and one cycle after each non-final write packet has been fully sent; a data-port write packs its strobed lanes in ascending lane order into the buffer and drops bytes beyond the packet size.
- R8: Once a write packet is full, `out_valid` rises one cycle later and the packet's bytes leave in buffered order, with `out_data` held while `out_valid` is high and `out_ready` low.
- R9: Transfer-complete is set one cycle after the final packet is emptied (read: its last byte popped through the data port; write: its last byte taken downstream) and never after an earlier packet; the block is then idle.
- R10: The inputs `ecc_multi_err` and `ecc_err` set status bits 3 and 4 respectively, subject to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops data port) |
| bus_addr | input | 2 | Word offset: 0 packet, 1 enable, 2 status, 3 data port |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes, used by data-port writes |
| bus_rdata | output | 32 | Read data for the addressed register |
| xfer_start | input | 1 | Start pulse from the command sequencer |
| xfer_is_read | input | 1 | Direction of the started transfer (1 = read) |
| in_valid | input | 1 | Inbound byte valid (flash to buffer) |
| in_ready | output | 1 | Inbound byte ready |
| in_data | input | 8 | Inbound byte |
| out_valid | output | 1 | Outbound byte valid (buffer to flash) |
| out_ready | input | 1 | Outbound byte ready |
| out_data | output | 8 | Outbound byte |
| ecc_err | input | 1 | ECC error event pulse |
| ecc_multi_err | input | 1 | Multi-bit ECC error event pulse |

## Verification
A wrong buffer pointer shows at the ports in the very next cycle: `in_ready` or `out_valid` disagrees with a reference that counts bytes, or the data-port word or outbound byte differs from what was buffered. A wrong sequencer phase or packet count shows as a ready flag or transfer-complete appearing one packet early or late, which the status read after each packet exposes. Status gating and clear priority are checked by reading the status register right after single-cycle events with chosen enable masks.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  // Word offsets on the register bus
  localparam logic [1:0] OFS_PKT  = 2'd0;
  localparam logic [1:0] OFS_EN   = 2'd1;
  localparam logic [1:0] OFS_STAT = 2'd2;
  localparam logic [1:0] OFS_DATA = 2'd3;

  // Packet count field starts here in the packet register
  localparam int CNT_LSB = 12;

  // Status bit positions
  localparam int NSTAT    = 5;
  localparam int ST_WRRDY = 0;
  localparam int ST_RDRDY = 1;
  localparam int ST_DONE  = 2;
  localparam int ST_MULTI = 3;
  localparam int ST_ECC   = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RFILL,
    PH_RDRAIN,
    PH_WFILL,
    PH_WDRAIN
  } phase_e;
endpackage

// File: rtl/pdp_regs.sv
module pdp_regs
  import pdp_pkg::*;
#(
  parameter int SIZE_W = 11,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [SIZE_W-1:0] wd_size,
  input  logic [CNT_W-1:0]  wd_cnt,
  input  logic [NSTAT-1:0]  set_ev,
  output logic [SIZE_W-1:0] pkt_size,
  output logic [CNT_W-1:0]  pkt_cnt,
  output logic [NSTAT-1:0]  stat_en,
  output logic [NSTAT-1:0]  stat
);
  logic [NSTAT-1:0] clr_mask;
  logic             wr_stat;

  assign wr_stat  = bus_wr && (bus_addr == OFS_STAT);
  assign clr_mask = wr_stat ? wd_size[NSTAT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_size <= '0;
      pkt_cnt  <= '0;
      stat_en  <= '0;
      stat     <= '0;
    end else begin
      if (bus_wr && (bus_addr == OFS_PKT)) begin
        pkt_size <= wd_size;
        pkt_cnt  <= wd_cnt;
      end
      if (bus_wr && (bus_addr == OFS_EN))
        stat_en <= wd_size[NSTAT-1:0];
      // set has priority over a same-cycle clear
      stat <= (stat & ~clr_mask) | (set_ev & stat_en);
    end
  end

  // R3: no bit rises unless it was enabled in the previous cycle
  assert_masked_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(stat_en)) == '0));

  // R2: a cleared bit with no enabled event in that cycle reads 0 afterwards
  assert_w1c_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat & $past(clr_mask & ~(set_ev & stat_en))) == '0));
endmodule

// File: rtl/pdp_seq.sv
module pdp_seq
  import pdp_pkg::*;
#(
  parameter int SIZE_W = 11,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_read,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              buf_full,
  input  logic              buf_empty,
  output phase_e            phase,
  output logic [SIZE_W-1:0] size_q,
  output logic              buf_clr,
  output logic              ev_wrrdy,
  output logic              ev_rdrdy,
  output logic              ev_done
);
  phase_e           nxt;
  logic [CNT_W-1:0] left_q;
  logic             load;
  logic             left_dec;
  logic             last_pkt;

  assign last_pkt = (left_q == CNT_W'(1));

  always_comb begin
    nxt      = phase;
    load     = 1'b0;
    left_dec = 1'b0;
    buf_clr  = 1'b0;
    ev_wrrdy = 1'b0;
    ev_rdrdy = 1'b0;
    ev_done  = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (start && (cfg_size != '0) && (cfg_cnt != '0)) begin
          load     = 1'b1;
          buf_clr  = 1'b1;
          nxt      = is_read ? PH_RFILL : PH_WFILL;
          ev_wrrdy = !is_read;
        end
      end
      PH_RFILL: begin
        if (buf_full) begin
          nxt      = PH_RDRAIN;
          ev_rdrdy = 1'b1;
        end
      end
      PH_WFILL: begin
        if (buf_full) nxt = PH_WDRAIN;
      end
      PH_RDRAIN, PH_WDRAIN: begin
        if (buf_empty) begin
          if (last_pkt) begin
            ev_done = 1'b1;
            nxt     = PH_IDLE;
          end else begin
            left_dec = 1'b1;
            buf_clr  = 1'b1;
            nxt      = (phase == PH_RDRAIN) ? PH_RFILL : PH_WFILL;
            ev_wrrdy = (phase == PH_WDRAIN);
          end
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      size_q <= '0;
      left_q <= '0;
    end else begin
      phase <= nxt;
      if (load) begin
        size_q <= cfg_size;
        left_q <= cfg_cnt;
      end else if (left_dec) begin
        left_q <= left_q - CNT_W'(1);
      end
    end
  end

  // R4: the latched packet size never changes while a transfer runs
  assert_size_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> (size_q == $past(size_q)));
endmodule

// File: rtl/pdp_pktbuf.sv
module pdp_pktbuf
  import pdp_pkg::*;
#(
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [SIZE_W-1:0] size,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              bus_fill,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              bus_pop,
  output logic [31:0]       pop_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              full,
  output logic              empty
);
  localparam int DEPTH = 1 << SIZE_W;
  localparam int LANES = 4;

  logic [7:0]        mem [DEPTH];
  logic [SIZE_W-1:0] wp_q, rp_q;
  logic [SIZE_W-1:0] room, avail;
  logic [SIZE_W-1:0] lane_idx [LANES];
  logic [LANES-1:0]  lane_ok;
  logic [2:0]        n_wr, n_pop;
  logic              fill_wr, drain_rd, in_hs, out_hs;

  assign room      = size - wp_q;
  assign avail     = size - rp_q;
  assign full      = (wp_q == size);
  assign empty     = (rp_q == size);
  assign in_ready  = (phase == PH_RFILL) && !full;
  assign out_valid = (phase == PH_WDRAIN) && !empty;
  assign out_data  = mem[rp_q];
  assign in_hs     = in_valid && in_ready;
  assign out_hs    = out_valid && out_ready;
  assign fill_wr   = bus_fill && (phase == PH_WFILL);
  assign drain_rd  = bus_pop && (phase == PH_RDRAIN);
  assign n_pop     = (avail >= SIZE_W'(LANES)) ? 3'd4 : avail[2:0];

  // Strobed lanes pack densely, lowest lane first; lanes past the room drop
  always_comb begin
    logic [2:0] off;
    off  = '0;
    n_wr = '0;
    for (int k = 0; k < LANES; k++) begin
      lane_idx[k] = wp_q + SIZE_W'(off);
      lane_ok[k]  = bus_be[k] && (SIZE_W'(off) < room);
      if (bus_be[k]) off = off + 3'd1;
      if (lane_ok[k]) n_wr = n_wr + 3'd1;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_pop
      assign pop_word[8*g +: 8] =
        ((phase == PH_RDRAIN) && (SIZE_W'(g) < avail)) ? mem[rp_q + SIZE_W'(g)] : 8'h00;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (in_hs) mem[wp_q] <= in_data;
    if (fill_wr) begin
      for (int k = 0; k < LANES; k++)
        if (lane_ok[k]) mem[lane_idx[k]] <= bus_wdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (in_hs)    wp_q <= wp_q + SIZE_W'(1);
      if (fill_wr)  wp_q <= wp_q + SIZE_W'(n_wr);
      if (drain_rd) rp_q <= rp_q + SIZE_W'(n_pop);
      if (out_hs)   rp_q <= rp_q + SIZE_W'(1);
    end
  end

  // R5: the fill pointer never passes the packet size
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (wp_q <= size));

  // R8: a stalled outbound byte stays valid and unchanged
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/pkt_dataport.sv
module pkt_dataport
  import pdp_pkg::*;
#(
  parameter int SIZE_W = 11,
  parameter int CNT_W  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_be,
  output logic [31:0] bus_rdata,
  input  logic        xfer_start,
  input  logic        xfer_is_read,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  input  logic        ecc_err,
  input  logic        ecc_multi_err
);
  logic [SIZE_W-1:0] pkt_size, size_q;
  logic [CNT_W-1:0]  pkt_cnt;
  logic [NSTAT-1:0]  stat_en, stat, set_ev;
  logic [31:0]       pop_word;
  phase_e            phase;
  logic              buf_clr, buf_full, buf_empty;
  logic              ev_wrrdy, ev_rdrdy, ev_done;

  always_comb begin
    set_ev           = '0;
    set_ev[ST_WRRDY] = ev_wrrdy;
    set_ev[ST_RDRDY] = ev_rdrdy;
    set_ev[ST_DONE]  = ev_done;
    set_ev[ST_MULTI] = ecc_multi_err;
    set_ev[ST_ECC]   = ecc_err;
  end

  pdp_regs #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wd_size  (bus_wdata[SIZE_W-1:0]),
    .wd_cnt   (bus_wdata[CNT_LSB +: CNT_W]),
    .set_ev   (set_ev),
    .pkt_size (pkt_size),
    .pkt_cnt  (pkt_cnt),
    .stat_en  (stat_en),
    .stat     (stat)
  );

  pdp_seq #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (xfer_start),
    .is_read   (xfer_is_read),
    .cfg_size  (pkt_size),
    .cfg_cnt   (pkt_cnt),
    .buf_full  (buf_full),
    .buf_empty (buf_empty),
    .phase     (phase),
    .size_q    (size_q),
    .buf_clr   (buf_clr),
    .ev_wrrdy  (ev_wrrdy),
    .ev_rdrdy  (ev_rdrdy),
    .ev_done   (ev_done)
  );

  pdp_pktbuf #(.SIZE_W(SIZE_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .size      (size_q),
    .clr       (buf_clr),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .bus_fill  (bus_wr && (bus_addr == OFS_DATA)),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .bus_pop   (bus_rd && (bus_addr == OFS_DATA)),
    .pop_word  (pop_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .full      (buf_full),
    .empty     (buf_empty)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_PKT: begin
        bus_rdata[SIZE_W-1:0]       = pkt_size;
        bus_rdata[CNT_LSB +: CNT_W] = pkt_cnt;
      end
      OFS_EN:   bus_rdata[NSTAT-1:0] = stat_en;
      OFS_STAT: bus_rdata[NSTAT-1:0] = stat;
      default:  bus_rdata = pop_word;
    endcase
  end
endmodule

// File: tb/pkt_dataport_tb.sv
module pkt_dataport_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_rdata;
  logic        xfer_start = 1'b0, xfer_is_read = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        ecc_err = 1'b0, ecc_multi_err = 1'b0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  pkt_dataport u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .xfer_start(xfer_start), .xfer_is_read(xfer_is_read),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ecc_err(ecc_err), .ecc_multi_err(ecc_multi_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int ph, m_wp, m_rp, m_sz, m_left, m_size_reg, m_cnt_reg;
  logic [7:0] mm [0:2047];

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_wp = 0; m_rp = 0; m_sz = 0; m_left = 0;
      m_size_reg = 0; m_cnt_reg = 0;
    end else begin
      case (ph)
        0: if (xfer_start && m_size_reg != 0 && m_cnt_reg != 0) begin
             m_sz = m_size_reg; m_left = m_cnt_reg; m_wp = 0; m_rp = 0;
             ph = xfer_is_read ? 1 : 3;
           end
        1: if (m_wp == m_sz) ph = 2;
           else if (in_valid) begin mm[m_wp] = in_data; m_wp++; end
        2: if (m_rp == m_sz) begin
             if (m_left == 1) ph = 0;
             else begin m_left--; m_wp = 0; m_rp = 0; ph = 1; end
           end else if (bus_rd && bus_addr == 2'd3)
             m_rp += ((m_sz - m_rp) >= 4) ? 4 : (m_sz - m_rp);
        3: if (m_wp == m_sz) ph = 4;
           else if (bus_wr && bus_addr == 2'd3) begin
             for (int k = 0; k < 4; k++)
               if (bus_be[k] && m_wp < m_sz) begin mm[m_wp] = bus_wdata[8*k +: 8]; m_wp++; end
           end
        4: if (m_rp == m_sz) begin
             if (m_left == 1) ph = 0;
             else begin m_left--; m_wp = 0; m_rp = 0; ph = 3; end
           end else if (out_ready) m_rp++;
        default: ph = 0;
      endcase
      if (bus_wr && bus_addr == 2'd0) begin
        m_size_reg = int'(bus_wdata[10:0]);
        m_cnt_reg  = int'(bus_wdata[23:12]);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_in, exp_ov;
      logic [31:0] exp_w;
      exp_in = (ph == 1) && (m_wp < m_sz);
      exp_ov = (ph == 4) && (m_rp < m_sz);
      chk(in_ready === exp_in, "R5 in_ready", 32'(in_ready), 32'(exp_in));
      chk(out_valid === exp_ov, "R8 out_valid", 32'(out_valid), 32'(exp_ov));
      if (exp_ov) chk(out_data === mm[m_rp], "R8 out_data", 32'(out_data), 32'(mm[m_rp]));
      if (bus_addr == 2'd3) begin
        exp_w = '0;
        if (ph == 2)
          for (int k = 0; k < 4; k++)
            if (m_rp + k < m_sz) exp_w[8*k +: 8] = mm[m_rp + k];
        chk(bus_rdata === exp_w, "R6 data port word", bus_rdata, exp_w);
      end
    end
  end

  // outbound byte collector
  logic [7:0] outq [$];
  always @(posedge clk) if (rst_n && out_valid && out_ready) outq.push_back(out_data);

  // ---------------- bus and stream tasks ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_addr = 2'd0; bus_be = 4'h0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #4 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic start_xfer(input logic rd);
    xfer_start = 1'b1; xfer_is_read = rd;
    tick();
    xfer_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic acc;
    in_valid = 1'b1; in_data = b;
    do begin @(posedge clk); acc = in_ready; #1; end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic drain_out(input int n, input bit toggle);
    while (outq.size() < n) begin
      out_ready = toggle ? ~out_ready : 1'b1;
      tick();
    end
    out_ready = 1'b0;
  endtask

  task automatic expect_stat(input logic [4:0] e, input string req);
    logic [31:0] d;
    reg_read(2'd2, d);
    chk(d === {27'd0, e}, req, d, {27'd0, e});
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [31:0] rd;
  logic [7:0] exp_bytes [12];

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state (R1, R2)
    reg_read(2'd0, rd); chk(rd === 32'h0, "R1 packet reg reset", rd, 32'h0);
    expect_stat(5'h00, "R2 status reset");
    reg_read(2'd1, rd); chk(rd === 32'h0, "R3 enable reset", rd, 32'h0);

    // R1 field layout
    reg_write(2'd0, 32'hFFFF_FFFF, 4'hF);
    reg_read(2'd0, rd); chk(rd === 32'h00FF_F7FF, "R1 field readback", rd, 32'h00FF_F7FF);

    // masked write transfer: size 8, one packet (R3, R4 busy start)
    reg_write(2'd0, (32'd1 << 12) | 32'd8, 4'hF);
    start_xfer(1'b0);
    expect_stat(5'h00, "R3 masked wr-ready");
    start_xfer(1'b1);                     // ignored while busy
    reg_write(2'd3, 32'h4433_2211, 4'hF);
    reg_write(2'd3, 32'h8877_6655, 4'hF);
    outq.delete();
    drain_out(8, 1'b0);
    tick(); tick();
    for (int i = 0; i < 8; i++)
      chk(outq[i] === 8'(8'h11 * (i + 1)), "R8 word order", 32'(outq[i]), 32'(8'h11 * (i + 1)));
    expect_stat(5'h00, "R3 masked complete");
    chk(in_ready === 1'b0, "R4 start ignored while busy", 32'(in_ready), 32'h0);

    // two-packet write with mixed strobes (R7, R8, R9)
    reg_write(2'd1, 32'h1F, 4'hF);
    reg_write(2'd0, (32'd2 << 12) | 32'd6, 4'hF);
    start_xfer(1'b0);
    expect_stat(5'h01, "R7 wr-ready on start");
    reg_write(2'd2, 32'h01, 4'hF);
    expect_stat(5'h00, "R2 write-one clears");
    reg_write(2'd3, 32'h0000_BBAA, 4'h3);
    reg_write(2'd3, 32'h00CC_0000, 4'h4);
    reg_write(2'd3, 32'h4433_2211, 4'hF);  // only three bytes fit
    outq.delete();
    drain_out(6, 1'b1);
    tick(); tick();
    expect_stat(5'h01, "R9 no complete after first packet / R7 wr-ready again");
    reg_write(2'd2, 32'h01, 4'hF);
    reg_write(2'd3, 32'h4433_2211, 4'hF);
    reg_write(2'd3, 32'h0000_6655, 4'h3);
    drain_out(12, 1'b1);
    tick(); tick();
    expect_stat(5'h04, "R9 complete after last write packet");
    exp_bytes = '{8'hAA, 8'hBB, 8'hCC, 8'h11, 8'h22, 8'h33,
                  8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    for (int i = 0; i < 12; i++)
      chk(outq[i] === exp_bytes[i], "R7 strobe packing", 32'(outq[i]), 32'(exp_bytes[i]));

    // two-packet read of 6 bytes each (R5, R6, R9)
    reg_write(2'd2, 32'h1F, 4'hF);
    start_xfer(1'b1);
    for (int i = 0; i < 6; i++) begin
      send_byte(8'(8'h10 + i));
      if (i == 2) begin tick(); tick(); end
    end
    tick();
    expect_stat(5'h02, "R5 rd-ready after full packet");
    chk(in_ready === 1'b0, "R5 in_ready low when full", 32'(in_ready), 32'h0);
    reg_write(2'd2, 32'h02, 4'hF);
    reg_read(2'd3, rd); chk(rd === 32'h1312_1110, "R6 first word", rd, 32'h1312_1110);
    reg_read(2'd3, rd); chk(rd === 32'h0000_1514, "R6 tail word", rd, 32'h0000_1514);
    tick();
    expect_stat(5'h00, "R9 no complete after first read packet");
    reg_read(2'd3, rd); chk(rd === 32'h0, "R6 read outside drain", rd, 32'h0);
    for (int i = 0; i < 6; i++) send_byte(8'(8'h20 + i));
    tick();
    expect_stat(5'h02, "R5 rd-ready second packet");
    reg_write(2'd2, 32'h02, 4'hF);
    reg_read(2'd3, rd); chk(rd === 32'h2322_2120, "R6 second packet word", rd, 32'h2322_2120);
    reg_read(2'd3, rd); chk(rd === 32'h0000_2524, "R6 second tail", rd, 32'h0000_2524);
    tick();
    expect_stat(5'h04, "R9 complete after last read packet");
    reg_write(2'd2, 32'h1F, 4'hF);

    // ECC events and set-over-clear (R10, R2, R3)
    reg_write(2'd1, 32'h10, 4'hF);
    ecc_err = 1'b1; ecc_multi_err = 1'b1; tick(); ecc_err = 1'b0; ecc_multi_err = 1'b0;
    expect_stat(5'h10, "R10 ecc error set, multi masked");
    ecc_err = 1'b1;
    reg_write(2'd2, 32'h10, 4'hF);
    ecc_err = 1'b0;
    expect_stat(5'h10, "R2 set wins over clear");
    reg_write(2'd2, 32'h10, 4'hF);
    expect_stat(5'h00, "R2 clear alone");
    reg_write(2'd1, 32'h08, 4'hF);
    ecc_multi_err = 1'b1; tick(); ecc_multi_err = 1'b0;
    expect_stat(5'h08, "R10 multi-bit error set");
    reg_write(2'd2, 32'h1F, 4'hF);

    // zero count / zero size starts ignored (R4)
    reg_write(2'd1, 32'h1F, 4'hF);
    reg_write(2'd0, 32'd4, 4'hF);
    start_xfer(1'b0);
    tick();
    expect_stat(5'h00, "R4 zero count ignored");
    reg_write(2'd0, (32'd1 << 12), 4'hF);
    start_xfer(1'b1);
    tick(); tick();
    chk(in_ready === 1'b0, "R4 zero size ignored", 32'(in_ready), 32'h0);
    expect_stat(5'h00, "R4 zero size no status");

    tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule